// File: doc/BRIEF.md
# Serial-Controlled DAC Register Front End

This block is the two-wire serial slave in front of a single-channel DAC. The system clock oversamples the clock and data lines. A synchronizer and a glitch filter clean both lines. The block then finds bus conditions on the cleaned values and runs a bit and byte engine for addressed write and read transfers.

A complete write frame carries one command byte and two data bytes holding a left-justified 12-bit code. The frame either sets the holding (CODE) register, moves the holding value into the output (DAC) register, or sets both. The DAC register can also take the holding value through an active-low load pin while load mode is on. A read returns either register, selected by the command byte written before a Repeated START.

No transfer here uses valid/ready. The serial bus cannot be stalled, so every byte that arrives is accepted at once. The internal received-byte stream is therefore valid-only and has no back-pressure. All other pins are plain levels.

Top module: `sdac_i2c_slave`

## Requirements
- R1: Only a START opens a transfer: SDA falling while SCL is high. After a STOP (SDA rising while SCL is high) the slave releases SDA and ignores bytes clocked without a new START.
- R2: The slave address is 7 bits, MSB first, followed by a R/W bit (1 = read). The upper five bits are 00110. The low two bits come from `strap_lvl`: 0 (tied low) gives 00, 1 (open) gives 10, 2 (tied high) gives 11, and 3 is treated as 0. On a match the slave pulls SDA low during the ninth clock.
- R3: For a non-matching address the slave leaves SDA released on the ninth clock. It then ignores the bus until the next START, and no register changes.
- R4: Command upper nibble 0x3 with data bytes D1, D2 sets CODE = {D1, D2[7:4]}. DAC stays unchanged. Each of the three frame bytes is ACKed.
- R5: Command upper nibble 0x2 copies CODE into DAC. Its data bytes are ignored.
- R6: Command upper nibble 0x4 sets both CODE and DAC to {D1, D2[7:4]}.
- R7: Command upper nibble 0x6 sets load mode to D2[0]. While load mode is on and `load_n` is low, DAC follows CODE within 3 clock cycles. While load mode is off, `load_n` has no effect.
- R8: A STOP before the third frame byte is complete leaves CODE, DAC and load mode unchanged.
- R9: A read returns two bytes: REG[11:4], then {REG[3:0], 0000}. REG is DAC when the last command byte, written before a Repeated START, has upper nibble 0x2; otherwise REG is CODE.
- R10: A STOP in the middle of a read byte abandons the read. The next read starts again from the first byte.
- R11: A STOP inside the same SCL-high interval as a START is taken as part of that START, so an address byte follows directly.
- R12: After reset, CODE and DAC are zero, load mode is off and SDA is released.
- R13: Bytes after the third byte of a write frame are NACKed and change nothing.
- R14: An SDA pulse shorter than 3 clock cycles is filtered out and does not form a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull_low | output | 1 | 1 = drive SDA low (open drain) |
| strap_lvl | input | 2 | Decoded strap level for the address LSBs |
| load_n | input | 1 | Active-low load pin, used in load mode |
| dac_code | output | DAC_BITS | DAC register value |

## Verification
A register change shows on `dac_code` before the STOP of its frame completes. The bench samples only after the STOP plus a settle interval, on the falling clock edge. A load-pin change takes three cycles: two synchronizer flops and the register. The bench waits six cycles before it compares. Each bus line first passes about five cycles of synchronizing and filtering, and the bench holds every SCL phase for ten cycles. As a result, the slave's ACK and read bits are stable by the middle of the SCL-high phase, where the bench samples them.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam logic [4:0] ADDR_UPPER = 5'b00110;
  localparam int FRAME_BYTES = 3;
  localparam int IDX_W = $clog2(FRAME_BYTES + 1);

  localparam logic [3:0] OP_LOAD   = 4'h2;
  localparam logic [3:0] OP_WRITE  = 4'h3;
  localparam logic [3:0] OP_WRLOAD = 4'h4;
  localparam logic [3:0] OP_MODE   = 4'h6;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_WRITE, PH_READ, PH_SKIP} phase_t;

  function automatic logic [1:0] strap_to_lsb(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return 2'b10;
      2'd2:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/sdac_line_filter.sv
module sdac_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};

  assign s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clean <= 1'b1;
      cnt   <= '0;
    end else if (s == clean) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      clean <= s;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end

  // R14
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean != $past(clean)) |-> ($past(s) == clean));
endmodule

// File: rtl/sdac_bus_cond.sv
module sdac_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d, start_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      start_hi <= 1'b0;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
      if (scl_fall)       start_hi <= 1'b0;
      else if (start_evt) start_hi <= 1'b1;
    end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign start_evt = scl & scl_d & sda_d & ~sda;
  // a rise in the same high interval as a START is folded into that START
  assign stop_evt  = scl & scl_d & ~sda_d & sda & ~start_hi;
endmodule

// File: rtl/sdac_link.sv
module sdac_link
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_in,
  input  logic [6:0]       dev_addr,
  input  logic [15:0]      rd_word,
  output logic             sda_low,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic [IDX_W-1:0] rx_idx
);
  phase_t           phase;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [6:0]       tx;
  logic             nack_q;
  logic             rd_sel;
  logic [IDX_W-1:0] idx;
  logic [7:0]       nb;

  assign nb = rd_sel ? rd_word[7:0] : rd_word[15:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      nack_q   <= 1'b0;
      rd_sel   <= 1'b0;
      idx      <= '0;
      sda_low  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_idx   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start_evt) begin
        phase   <= PH_ADDR;
        bitcnt  <= '0;
        idx     <= '0;
        sda_low <= 1'b0;
      end else if (stop_evt) begin
        phase   <= PH_IDLE;
        sda_low <= 1'b0;
      end else if (scl_rise) begin
        case (phase)
          PH_ADDR, PH_WRITE: begin
            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
          end
          PH_READ: begin
            if (bitcnt == 4'd8) nack_q <= sda_in;
            bitcnt <= bitcnt + 4'd1;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (phase)
          PH_ADDR: begin
            if (bitcnt == 4'd8) begin
              if (shreg[7:1] == dev_addr) sda_low <= 1'b1;
              else                        phase   <= PH_SKIP;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (shreg[0]) begin
                phase   <= PH_READ;
                tx      <= rd_word[14:8];
                sda_low <= ~rd_word[15];
                rd_sel  <= 1'b1;
              end else begin
                phase   <= PH_WRITE;
                sda_low <= 1'b0;
              end
            end
          end
          PH_WRITE: begin
            if (bitcnt == 4'd8) begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
              rx_idx   <= idx;
              sda_low  <= (idx < IDX_W'(FRAME_BYTES));
              if (idx < IDX_W'(FRAME_BYTES)) idx <= idx + 1'b1;
            end else if (bitcnt == 4'd9) begin
              sda_low <= 1'b0;
              bitcnt  <= '0;
            end
          end
          PH_READ: begin
            if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
              sda_low <= ~tx[6];
              tx      <= {tx[5:0], 1'b0};
            end else if (bitcnt == 4'd8) begin
              sda_low <= 1'b0;
            end else if (bitcnt == 4'd9) begin
              if (!nack_q) begin
                tx      <= nb[6:0];
                sda_low <= ~nb[7];
                rd_sel  <= ~rd_sel;
                bitcnt  <= '0;
              end else begin
                phase   <= PH_SKIP;
                sda_low <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_low && phase == PH_IDLE));
  // R11
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (phase == PH_ADDR && bitcnt == 4'd0));
  // R2
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(scl_fall));
  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && !start_evt) |=> !sda_low);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int DAC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_evt,
  input  logic                stop_evt,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic [IDX_W-1:0]    rx_idx,
  input  logic                load_n,
  output logic [DAC_BITS-1:0] dac_q,
  output logic [15:0]         rd_word
);
  localparam int PAD = 16 - DAC_BITS;

  logic [3:0]          op_q;
  logic [7:0]          d1_q;
  logic                have_cmd;
  logic                rd_dac;
  logic                lmode_q;
  logic [1:0]          ld_sync;
  logic [DAC_BITS-1:0] code_q;
  logic [DAC_BITS-1:0] new_code;
  logic                commit;
  logic                pin_act;

  assign commit   = rx_valid && (rx_idx == IDX_W'(FRAME_BYTES - 1)) && have_cmd;
  assign new_code = DAC_BITS'({d1_q, rx_data} >> PAD);
  assign pin_act  = lmode_q & ~ld_sync[1];
  assign rd_word  = {(rd_dac ? dac_q : code_q), {PAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ld_sync <= 2'b11;
    else        ld_sync <= {ld_sync[0], load_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q     <= '0;
      d1_q     <= '0;
      have_cmd <= 1'b0;
      rd_dac   <= 1'b0;
      lmode_q  <= 1'b0;
      code_q   <= '0;
    end else if (start_evt || stop_evt) begin
      // pending frame is dropped; a restart keeps its pointer
      have_cmd <= 1'b0;
      if (start_evt && have_cmd) rd_dac <= (op_q == OP_LOAD);
    end else if (rx_valid) begin
      if (rx_idx == '0) begin
        op_q     <= rx_data[7:4];
        have_cmd <= 1'b1;
      end else if (rx_idx == IDX_W'(1)) begin
        d1_q <= rx_data;
      end else if (commit) begin
        have_cmd <= 1'b0;
        rd_dac   <= (op_q == OP_LOAD);
        case (op_q)
          OP_WRITE, OP_WRLOAD: code_q  <= new_code;
          OP_MODE:             lmode_q <= rx_data[0];
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               dac_q <= '0;
    else if (commit && op_q == OP_WRLOAD)     dac_q <= new_code;
    else if (commit && op_q == OP_LOAD)       dac_q <= code_q;
    else if (pin_act)                         dac_q <= code_q;

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_idx == IDX_W'(FRAME_BYTES - 1)) |=> $stable(code_q));
  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_valid && rx_idx == IDX_W'(FRAME_BYTES - 1)) && !pin_act) |=> $stable(dac_q));
  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(lmode_q));
endmodule

// File: rtl/sdac_i2c_slave.sv
module sdac_i2c_slave
  import sdac_pkg::*;
#(
  parameter int DAC_BITS = 12,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_pull_low,
  input  logic [1:0]          strap_lvl,
  input  logic                load_n,
  output logic [DAC_BITS-1:0] dac_code
);
  logic [1:0]       raw_lines;
  logic [1:0]       clean_lines;
  logic             start_evt, stop_evt, scl_rise, scl_fall;
  logic [6:0]       dev_addr;
  logic [15:0]      rd_word;
  logic             rx_valid;
  logic [7:0]       rx_data;
  logic [IDX_W-1:0] rx_idx;

  assign raw_lines = {sda_in, scl_in};
  assign dev_addr  = {ADDR_UPPER, strap_to_lsb(strap_lvl)};

  for (genvar i = 0; i < 2; i++) begin : g_line
    sdac_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[i]), .clean(clean_lines[i])
    );
  end

  sdac_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(clean_lines[0]), .sda(clean_lines[1]),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  sdac_link u_link (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(clean_lines[1]),
    .dev_addr(dev_addr), .rd_word(rd_word), .sda_low(sda_pull_low),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx)
  );

  sdac_regs #(.DAC_BITS(DAC_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx), .load_n(load_n),
    .dac_q(dac_code), .rd_word(rd_word)
  );
endmodule

// File: tb/sdac_i2c_slave_tb.sv
module sdac_i2c_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, load_n = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_pl;
  logic [11:0] dac;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pl;

  sdac_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull_low(sda_pl), .strap_lvl(strap), .load_n(load_n), .dac_code(dac)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  logic [11:0] m_code = '0, m_dac = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  function automatic logic [6:0] addr_for(input logic [1:0] s);
    case (s)
      2'd1: return 7'b0011010;
      2'd2: return 7'b0011011;
      default: return 7'b0011000;
    endcase
  endfunction

  function automatic void apply(input logic [7:0] c, input logic [7:0] d1, input logic [7:0] d2);
    case (c[7:4])
      4'h3: m_code = {d1, d2[7:4]};
      4'h4: begin m_code = {d1, d2[7:4]}; m_dac = m_code; end
      4'h2: m_dac = m_code;
      default: ;
    endcase
  endfunction

  task automatic bus_start(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic bus_stop();  sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); qw(); endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; qw(); scl_m = 1; qw(); s = sda_bus; qw(); scl_m = 0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output int ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = (s == 1'b0) ? 1 : 0;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 0; i < 8; i++) begin clock_bit(1'b1, s); v = {v[6:0], s}; end
    clock_bit(~mack, s);
  endtask

  task automatic wr_frame(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d1,
                          input logic [7:0] d2, output int acks);
    int k;
    acks = 0;
    bus_start();
    wr_byte({a, 1'b0}, k); acks += k;
    wr_byte(c, k); acks += k;
    wr_byte(d1, k); acks += k;
    wr_byte(d2, k); acks += k;
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [11:0] v);
    int k;
    logic [7:0] b0, b1;
    bus_start();
    wr_byte({addr_for(strap), 1'b0}, k);
    wr_byte(c, k);
    bus_start();
    wr_byte({addr_for(strap), 1'b1}, k);
    rd_byte(1'b1, b0);
    rd_byte(1'b0, b1);
    bus_stop();
    v = {b0, b1[7:4]};
    chk("R9 read low nibble pad", int'(b1[3:0]), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int acks, k;
    logic s;
    logic [11:0] v;
    logic [7:0] b0, b1;
    void'($urandom(32'h5eed_0017));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    chk("R12 dac after reset", int'(dac), 0);
    chk("R12 sda released after reset", int'(sda_pl), 0);
    rd_reg(8'h30, v);
    chk("R12 code after reset", int'(v), 0);

    wr_frame(addr_for(strap), 8'h30, 8'h7C, 8'h15, acks); apply(8'h30, 8'h7C, 8'h15);
    chk("R4 write acks", acks, 4);
    chk("R4 dac untouched by write", int'(dac), int'(m_dac));
    chk("R1 sda released after stop", int'(sda_pl), 0);
    rd_reg(8'h30, v);
    chk("R4 code readback", int'(v), int'(m_code));

    load_n = 0; repeat (6) @(negedge clk);
    chk("R7 pin ignored with mode off (R12)", int'(dac), int'(m_dac));
    load_n = 1; repeat (6) @(negedge clk);

    wr_frame(addr_for(strap), 8'h20, 8'hFF, 8'hFF, acks); apply(8'h20, 8'hFF, 8'hFF);
    chk("R5 load copies code", int'(dac), int'(m_dac));
    rd_reg(8'h20, v);
    chk("R9 dac readback", int'(v), int'(m_dac));

    wr_frame(addr_for(strap), 8'h40, 8'hA5, 8'hC0, acks); apply(8'h40, 8'hA5, 8'hC0);
    chk("R6 write and load", int'(dac), int'(m_dac));

    wr_frame(7'h19, 8'h40, 8'h11, 8'h10, acks);
    chk("R3 wrong address not acked", acks, 0);
    chk("R3 dac unchanged", int'(dac), int'(m_dac));
    rd_reg(8'h30, v);
    chk("R3 code unchanged", int'(v), int'(m_code));

    for (int st = 1; st <= 3; st++) begin
      strap = 2'(st);
      bus_start(); wr_byte({addr_for(strap), 1'b0}, k); bus_stop();
      chk("R2 strap address acked", k, 1);
      bus_start(); wr_byte({addr_for(2'(st - 1)), 1'b0}, k); bus_stop();
      chk("R2 other address nacked", k, (addr_for(2'(st - 1)) == addr_for(strap)) ? 1 : 0);
    end
    strap = 2'd1;

    bus_start(); wr_byte({addr_for(strap), 1'b0}, k); wr_byte(8'h40, k); wr_byte(8'h3C, k);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
    bus_stop();
    chk("R8 early stop dac", int'(dac), int'(m_dac));
    rd_reg(8'h30, v);
    chk("R8 early stop code", int'(v), int'(m_code));

    bus_start(); wr_byte({addr_for(strap), 1'b0}, k); wr_byte(8'h30, k); wr_byte(8'h12, k);
    wr_byte(8'h30, k); wr_byte(8'h99, k); bus_stop(); apply(8'h30, 8'h12, 8'h30);
    chk("R13 extra byte nacked", k, 0);
    rd_reg(8'h30, v);
    chk("R13 extra byte ignored", int'(v), int'(m_code));

    wr_frame(addr_for(strap), 8'h60, 8'h00, 8'h01, acks);
    wr_frame(addr_for(strap), 8'h30, 8'h6E, 8'h70, acks); apply(8'h30, 8'h6E, 8'h70);
    chk("R7 dac holds before pin", int'(dac), int'(m_dac));
    load_n = 0; repeat (6) @(negedge clk); m_dac = m_code;
    chk("R7 pin loads dac", int'(dac), int'(m_dac));
    wr_frame(addr_for(strap), 8'h30, 8'h2B, 8'h90, acks); apply(8'h30, 8'h2B, 8'h90);
    m_dac = m_code;
    chk("R7 dac follows while pin low", int'(dac), int'(m_dac));
    load_n = 1; repeat (6) @(negedge clk);
    wr_frame(addr_for(strap), 8'h60, 8'h00, 8'h00, acks);

    wr_frame(addr_for(strap), 8'h30, 8'h5A, 8'h30, acks); apply(8'h30, 8'h5A, 8'h30);
    bus_start(); wr_byte({addr_for(strap), 1'b0}, k); wr_byte(8'h30, k);
    bus_start(); wr_byte({addr_for(strap), 1'b1}, k);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
    bus_stop();
    chk("R10 sda released after aborted read", int'(sda_pl), 0);
    bus_start(); wr_byte({addr_for(strap), 1'b0}, k); wr_byte(8'h30, k);
    bus_start(); wr_byte({addr_for(strap), 1'b1}, k);
    rd_byte(1'b1, b0); rd_byte(1'b0, b1); bus_stop();
    chk("R10 read restarts first byte", int'(b0), int'(m_code[11:4]));
    chk("R10 read second byte", int'(b1), int'({m_code[3:0], 4'h0}));

    sda_m = 0; qw(); sda_m = 1; qw(); scl_m = 0; qw();
    wr_byte({addr_for(strap), 1'b0}, k); wr_byte(8'h40, k); wr_byte(8'hD2, k); wr_byte(8'h40, k);
    bus_stop(); apply(8'h40, 8'hD2, 8'h40);
    chk("R11 start-stop pair acts as start", int'(dac), int'(m_dac));

    scl_m = 0; qw();
    wr_byte({addr_for(strap), 1'b0}, acks); wr_byte(8'h40, k); wr_byte(8'h01, k); wr_byte(8'h10, k);
    bus_stop();
    chk("R1 no start no ack", acks, 0);
    chk("R1 no start no change", int'(dac), int'(m_dac));

    @(negedge clk) sda_m = 0; @(negedge clk) sda_m = 1; qw();
    scl_m = 0; qw();
    wr_byte({addr_for(strap), 1'b0}, acks); wr_byte(8'h40, k); wr_byte(8'h02, k); wr_byte(8'h20, k);
    bus_stop();
    chk("R14 glitch not a start", acks, 0);
    chk("R14 glitch no change", int'(dac), int'(m_dac));

    for (int n = 0; n < 14; n++) begin
      logic [7:0] c, d1, d2;
      int pick;
      pick = int'($urandom_range(0, 2));
      c  = (pick == 0) ? 8'h30 : (pick == 1) ? 8'h40 : 8'h20;
      c[3:0] = 4'($urandom);
      d1 = 8'($urandom);
      d2 = 8'($urandom);
      wr_frame(addr_for(strap), c, d1, d2, acks); apply(c, d1, d2);
      chk("R4 random frame acks", acks, 4);
      chk("R6 random dac", int'(dac), int'(m_dac));
      rd_reg(8'h30, v);
      chk("R9 random code readback", int'(v), int'(m_code));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule